// File: doc/BRIEF.md
# Dual-Clock Sine Lookup Generator

This block turns one shared table of signed sine samples into two independent sine waveforms. The table holds exactly one period and is read through two ports. Each port has its own clock, its own reset and its own free-running ramp counter, which serves as the phase. Each clock edge advances the phase by one step. The sample at that phase is registered out one edge later. The output frequency of a port is therefore its clock rate divided by the table depth. A port clocked twice as fast produces a sine of twice the frequency.

The table contents are computed when the design is elaborated, so no initialization file is needed. The two ports share only the constant table contents. No signal crosses between the two clock domains. Both ports run all the time and have no enable input.

Top module: `dual_sine_lut`

## Requirements
- R1: Table entry n (n = 0..1023) is floor(1023 * sin(2*pi*n/1024)), held as an 11-bit two's-complement value, so every sample lies in the range -1023..+1023.
- R2: The entry at phase 0 is 0, the entry at phase 256 is +1023 and the entry at phase 768 is -1023.
- R3: After each rising edge of a port's clock, that port's sample output equals the table entry at the phase value the port held just before that edge (one cycle of read latency, with no extra output stage).
- R4: Out of reset, each port's 10-bit phase output rises by exactly one on every rising edge of its own clock and wraps from 1023 to 0.
- R5: Driving a port's active-low reset low clears that port's phase and sample to 0 at once, without waiting for a clock edge. The other port keeps its phase sequence unchanged.
- R6: Reset release is synchronized with two flops. The phase leaves 0 and reads 1 after the third rising edge that follows the release.
- R7: When port B is clocked at twice the rate of port A, port B completes twice as many phase wraps (sine periods) as port A over the same time window.
- R8: Both ports run continuously with no enable input. Every clock edge out of reset advances the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of port A |
| rst_a_n | input | 1 | Asynchronous active-low reset of port A |
| clk_b | input | 1 | Clock of port B |
| rst_b_n | input | 1 | Asynchronous active-low reset of port B |
| phase_a | output | 10 | Ramp counter (phase) of port A |
| sample_a | output | 11 | Signed sine sample of port A |
| phase_b | output | 10 | Ramp counter (phase) of port B |
| sample_b | output | 11 | Signed sine sample of port B |

## Verification
A port's phase moves on every edge of its own clock. Its sample shows the table entry one edge after that phase was presented. After reset release the phase stays at 0 for two more edges, then counts from the third. Reset assertion clears the port's outputs within the same cycle. The bench counts the edges of each clock on its own and derives the expected phase and the expected sample from that count and from a table it computes itself. It compares both outputs at every falling edge, half a period after the edge that changed them, and it checks the three peak samples by literal value. The frequency ratio is checked from wrap counts over a window long enough that edge alignment cannot change the result.

// File: rtl/dual_sine_pkg.sv
package dual_sine_pkg;
  localparam real TWO_PI = 6.283185307179586476925;

  // Floor-quantized sine entry n of a table of 'depth' entries, scaled by 'amp'
  function automatic int sine_entry(input int n, input int depth, input int amp);
    real ang;
    real val;
    ang = TWO_PI * real'(n) / real'(depth);
    val = real'(amp) * $sin(ang);
    return $rtoi($floor(val));
  endfunction
endpackage

// File: rtl/sine_rst_sync.sv
module sine_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/sine_phase_ctr.sv
module sine_phase_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  output logic [ADDR_W-1:0] phase
);
  logic [ADDR_W-1:0] phase_q;
  logic [ADDR_W-1:0] phase_d;

  always_comb begin
    phase_d = phase_q;
    if (step_en) phase_d = phase_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/sine_lut_read.sv
module sine_lut_read #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic signed [DATA_W-1:0] tbl [DEPTH],
  output logic signed [DATA_W-1:0] q
);
  logic signed [DATA_W-1:0] q_q;
  logic signed [DATA_W-1:0] q_d;

  always_comb q_d = tbl[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/dual_sine_lut.sv
module dual_sine_lut #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 11
) (
  input  logic                     clk_a,
  input  logic                     rst_a_n,
  input  logic                     clk_b,
  input  logic                     rst_b_n,
  output logic [ADDR_W-1:0]        phase_a,
  output logic signed [DATA_W-1:0] sample_a,
  output logic [ADDR_W-1:0]        phase_b,
  output logic signed [DATA_W-1:0] sample_b
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int AMP     = (1 << (DATA_W - 1)) - 1;
  localparam int N_PORTS = 2;

  // Shared one-period table, computed at elaboration
  logic signed [DATA_W-1:0] sine_tbl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
    assign sine_tbl[i] = DATA_W'(dual_sine_pkg::sine_entry(i, DEPTH, AMP));
  end

  logic                     clk_v   [N_PORTS];
  logic                     arst_v  [N_PORTS];
  logic [ADDR_W-1:0]        phase_v [N_PORTS];
  logic signed [DATA_W-1:0] samp_v  [N_PORTS];

  assign clk_v[0]  = clk_a;
  assign clk_v[1]  = clk_b;
  assign arst_v[0] = rst_a_n;
  assign arst_v[1] = rst_b_n;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic srst_n;

    sine_rst_sync u_sync (
      .clk    (clk_v[p]),
      .arst_n (arst_v[p]),
      .srst_n (srst_n)
    );

    sine_phase_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk     (clk_v[p]),
      .rst_n   (srst_n),
      .step_en (1'b1),
      .phase   (phase_v[p])
    );

    sine_lut_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk   (clk_v[p]),
      .rst_n (srst_n),
      .addr  (phase_v[p]),
      .tbl   (sine_tbl),
      .q     (samp_v[p])
    );
  end

  assign phase_a  = phase_v[0];
  assign sample_a = samp_v[0];
  assign phase_b  = phase_v[1];
  assign sample_b = samp_v[1];
endmodule

// File: rtl/dual_sine_lut_chk.sv
module dual_sine_lut_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 11
) (
  input logic                     clk_a,
  input logic                     rst_a_n,
  input logic                     clk_b,
  input logic                     rst_b_n,
  input logic [ADDR_W-1:0]        phase_a,
  input logic signed [DATA_W-1:0] sample_a,
  input logic [ADDR_W-1:0]        phase_b,
  input logic signed [DATA_W-1:0] sample_b
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AMP   = (1 << (DATA_W - 1)) - 1;
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);
  localparam logic signed [DATA_W-1:0] NEG_LIM = DATA_W'(-AMP);

  // R4
  phase_step_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (phase_a != '0 && phase_a != TOP) |=> phase_a == ADDR_W'($past(phase_a) + ADDR_W'(1)));
  // R4
  phase_wrap_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (phase_a == TOP) |=> phase_a == '0);
  // R4
  phase_step_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (phase_b != '0 && phase_b != TOP) |=> phase_b == ADDR_W'($past(phase_b) + ADDR_W'(1)));
  // R4
  phase_wrap_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (phase_b == TOP) |=> phase_b == '0);
  // R3
  read_lat_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    1'b1 |=> sample_a == DATA_W'(dual_sine_pkg::sine_entry(int'($past(phase_a)), DEPTH, AMP)));
  // R3
  read_lat_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    1'b1 |=> sample_b == DATA_W'(dual_sine_pkg::sine_entry(int'($past(phase_b)), DEPTH, AMP)));
  // R5
  rst_clear_a_chk: assert property (@(posedge clk_a)
    !rst_a_n |-> (phase_a == '0 && sample_a == '0));
  // R5
  rst_clear_b_chk: assert property (@(posedge clk_b)
    !rst_b_n |-> (phase_b == '0 && sample_b == '0));
  // R1
  range_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    sample_a >= NEG_LIM);
  // R1
  range_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    sample_b >= NEG_LIM);
endmodule

bind dual_sine_lut dual_sine_lut_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_a    (clk_a),
  .rst_a_n  (rst_a_n),
  .clk_b    (clk_b),
  .rst_b_n  (rst_b_n),
  .phase_a  (phase_a),
  .sample_a (sample_a),
  .phase_b  (phase_b),
  .sample_b (sample_b)
);

// File: tb/tb_dual_sine_lut.sv
`timescale 1ns/1ps
module tb_dual_sine_lut;
  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_a_n = 1'b0;
  logic rst_b_n = 1'b0;
  logic [9:0]        phase_a, phase_b;
  logic signed [10:0] sample_a, sample_b;

  int checks = 0;
  int errors = 0;
  int ref_tab [1024];
  int k_a = 0, k_b = 0;
  int prev_pa = 0, prev_pb = 0;
  int wraps_a = 0, wraps_b = 0;
  int cyc = 0;
  bit seen0 = 0, seen256 = 0, seen768 = 0;

  always #4 clk_a = ~clk_a;   // 125 MHz
  always #2 clk_b = ~clk_b;   // twice port A's rate

  dual_sine_lut dut (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
    .phase_a(phase_a), .sample_a(sample_a), .phase_b(phase_b), .sample_b(sample_b)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_phase(input int k);
    return (k >= 2) ? (k - 2) % 1024 : 0;
  endfunction

  function automatic int exp_sample(input int k);
    return (k >= 3) ? ref_tab[(k - 3) % 1024] : 0;
  endfunction

  // Edge counters since the last reset release, one per domain
  always @(posedge clk_a) if (!rst_a_n) k_a = 0; else k_a = k_a + 1;
  always @(negedge rst_a_n) k_a = 0;
  always @(posedge clk_b) if (!rst_b_n) k_b = 0; else k_b = k_b + 1;
  always @(negedge rst_b_n) k_b = 0;

  // Port A compare: R4/R6/R8 on phase, R1/R3 on sample, R2 on peaks
  always @(negedge clk_a) begin
    check(int'(phase_a) == exp_phase(k_a), "R4/R6/R8 phase_a", int'(phase_a), exp_phase(k_a));
    check(int'(sample_a) == exp_sample(k_a), "R1/R3 sample_a", int'(sample_a), exp_sample(k_a));
    if (k_a >= 3 && (k_a - 3) % 1024 == 0 && !seen0) begin
      seen0 = 1; check(sample_a == 11'sd0, "R2 sample at 0", int'(sample_a), 0);
    end
    if (k_a >= 3 && (k_a - 3) % 1024 == 256 && !seen256) begin
      seen256 = 1; check(sample_a == 11'sd1023, "R2 sample at 256", int'(sample_a), 1023);
    end
    if (k_a >= 3 && (k_a - 3) % 1024 == 768 && !seen768) begin
      seen768 = 1; check(sample_a == -11'sd1023, "R2 sample at 768", int'(sample_a), -1023);
    end
    if (prev_pa == 1023 && phase_a == 10'd0) wraps_a++;
    prev_pa = int'(phase_a);
  end

  // Port B compare
  always @(negedge clk_b) begin
    check(int'(phase_b) == exp_phase(k_b), "R4/R8 phase_b", int'(phase_b), exp_phase(k_b));
    check(int'(sample_b) == exp_sample(k_b), "R1/R3 sample_b", int'(sample_b), exp_sample(k_b));
    if (prev_pb == 1023 && phase_b == 10'd0) wraps_b++;
    prev_pb = int'(phase_b);
  end

  // Watchdog
  always @(posedge clk_a) begin
    cyc++;
    if (cyc > 30000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 30000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 1024; n++)
      ref_tab[n] = $rtoi($floor(1023.0 * $sin(2.0 * 3.14159265358979323846 * n / 1024.0)));

    // Reset state (R5)
    repeat (3) @(negedge clk_a);
    #1;
    check(phase_a == 10'd0 && sample_a == 11'sd0, "R5 reset state A", int'(phase_a), 0);
    check(phase_b == 10'd0 && sample_b == 11'sd0, "R5 reset state B", int'(phase_b), 0);

    // Release both together, then count periods over a common window (R7)
    rst_a_n = 1'b1;
    rst_b_n = 1'b1;
    wraps_a = 0;
    wraps_b = 0;
    #36864;
    check(wraps_a == 4, "R7 port A periods", wraps_a, 4);
    check(wraps_b == 2 * wraps_a, "R7 port B twice A", wraps_b, 2 * wraps_a);

    // Reset port A alone mid-run (R5); port B keeps its sequence via its own compare
    @(negedge clk_a);
    #1;
    rst_a_n = 1'b0;
    #1;
    check(phase_a == 10'd0, "R5 async clear phase_a", int'(phase_a), 0);
    check(sample_a == 11'sd0, "R5 async clear sample_a", int'(sample_a), 0);
    check(k_b > 9000 && int'(phase_b) == exp_phase(k_b), "R5 port B undisturbed", int'(phase_b), exp_phase(k_b));
    repeat (5) @(negedge clk_a);
    #1;
    rst_a_n = 1'b1;
    // Phase holds for two edges then steps (R6)
    @(posedge clk_a); #1;
    check(phase_a == 10'd0, "R6 hold after edge 1", int'(phase_a), 0);
    @(posedge clk_a); #1;
    check(phase_a == 10'd0, "R6 hold after edge 2", int'(phase_a), 0);
    @(posedge clk_a); #1;
    check(phase_a == 10'd1, "R6 step after edge 3", int'(phase_a), 1);

    repeat (1500) @(negedge clk_a);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule